// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block sits between a synchronous host and an asynchronous static RAM of 256K bytes. The RAM has two chip selects of opposite polarity, an active-low write strobe and an active-low output enable. The host issues one-beat requests through a valid/ready handshake. Each request is either a write, carrying an address and a data byte, or a read, carrying only an address. The controller turns each request into a fixed sequence of memory pin states, one state per clock.

A write runs for four clocks. In order, the controller selects the chip, pulses the write strobe with the byte driven, releases the strobe while everything else holds, and releases the selects. The bus driver switches off on the return to idle. A read selects the chip, then holds the output enable low for a configurable number of wait clocks. It samples the byte on the last wait clock, then releases the enable and the selects together. The sampled byte is returned with a single-clock valid pulse.

Between requests the chip is deselected: the controller's driver is off, the output enable is high and the strobe is high. The RAM therefore stays in its standby state while the host is idle.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: After reset and whenever idle, the pins are: `mem_s1`=1, `mem_s2`=0, `mem_we_n`=1, `mem_oe_n`=1 and `mem_dq_oe`=0. Also `req_ready`=1 and `rsp_valid`=0.
- R2: An accepted write occupies exactly four clocks, listed here as (s1, we_n, oe_n, dq_oe):
  - setup (0,1,1,0)
  - strobe (0,0,1,1)
  - hold (0,1,1,1)
  - release (1,1,1,1)
- R3: Address and write data do not change during any clock in which the chip stays selected or the driver stays enabled. The memory therefore captures the driven byte at the rising edge of `mem_we_n`.
- R4: `mem_dq_oe` is never 1 while `mem_oe_n` is 0.
- R5: An accepted read is one setup clock (0,1,1,0) followed by RD_WAIT clocks with `mem_oe_n`=0 (0,1,0,0). The byte on `mem_dq_in` at the end of the last wait clock appears on `rsp_rdata`, with `rsp_valid`=1 for exactly the one clock that follows.
- R6: Every access ends with one release clock in which the chip is deselected, `mem_we_n` is 1 and `mem_oe_n` is 1. `req_ready` rises only after that clock.
- R7: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the clock after acceptance until the access has finished. A request presented while busy has no effect on the pins or on the memory contents.
- R8: `mem_s2` is always the inverse of `mem_s1`.
- R9: `rsp_valid` is never raised by a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write byte |
| req_ready | output | 1 | Controller idle, request may be accepted |
| rsp_valid | output | 1 | One-clock pulse with read data |
| rsp_rdata | output | DATA_W | Read byte |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_s1 | output | 1 | Chip select, active low |
| mem_s2 | output | 1 | Chip select, active high |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | DATA_W | Byte driven toward the memory |
| mem_dq_oe | output | 1 | Enable for the bidirectional bus driver |
| mem_dq_in | input | DATA_W | Byte received from the memory |

## Verification
The read response pulse and the arrival of the next host request can land in the same clock. The bench provokes this by presenting a write in the very clock where `rsp_valid` is high. It then checks three things:
- the returned byte is correct;
- the write is not taken until the controller reaches idle one clock later;
- its setup clock then carries the new address with the chip reselected.

A second case holds a conflicting request asserted throughout a write. A later readback judges whether that request disturbed the memory.

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl #(
  parameter int ADDR_W  = 18,
  parameter int DATA_W  = 8,
  parameter int RD_WAIT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_s1,
  output logic              mem_s2,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int CNT_W = (RD_WAIT > 1) ? $clog2(RD_WAIT) : 1;
  localparam logic [CNT_W-1:0] LAST_WAIT = CNT_W'(RD_WAIT - 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_WSET, ST_WSTB, ST_WHLD, ST_WREL, ST_RSET, ST_RWAIT, ST_RREL
  } state_t;

  state_t            st;
  logic [CNT_W-1:0]  wcnt;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      wcnt      <= '0;
      addr_q    <= '0;
      wdata_q   <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (st)
        ST_IDLE: if (req_valid) begin
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          st      <= req_write ? ST_WSET : ST_RSET;
        end
        ST_WSET: st <= ST_WSTB;
        ST_WSTB: st <= ST_WHLD;
        ST_WHLD: st <= ST_WREL;
        ST_WREL: st <= ST_IDLE;
        ST_RSET: begin
          wcnt <= '0;
          st   <= ST_RWAIT;
        end
        ST_RWAIT: if (wcnt == LAST_WAIT) begin
          rsp_rdata <= mem_dq_in;
          rsp_valid <= 1'b1;
          st        <= ST_RREL;
        end else begin
          wcnt <= wcnt + 1'b1;
        end
        ST_RREL: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign req_ready  = (st == ST_IDLE);
  assign sel        = st inside {ST_WSET, ST_WSTB, ST_WHLD, ST_RSET, ST_RWAIT};
  assign mem_s1     = ~sel;
  assign mem_s2     = sel;
  assign mem_we_n   = (st != ST_WSTB);
  assign mem_oe_n   = (st != ST_RWAIT);
  assign mem_dq_oe  = st inside {ST_WSTB, ST_WHLD, ST_WREL};
  assign mem_dq_out = wdata_q;
  assign mem_addr   = addr_q;

endmodule

// File: rtl/sram_cycle_ctrl_chk.sv
module sram_cycle_ctrl_chk #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_dq_out,
  input logic              mem_s1,
  input logic              mem_s2,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_dq_oe
);

  AST_IDLE_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_s1 && !mem_s2 && mem_we_n && mem_oe_n && !mem_dq_oe && !rsp_valid)); // R1
  AST_STROBE_FRAMED: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_s1 && mem_oe_n && mem_dq_oe)); // R2
  AST_STROBE_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |=> mem_we_n); // R2
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_s1 && !$past(mem_s1)) |-> $stable(mem_addr)); // R3
  AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out)); // R3
  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n); // R4
  AST_RSP_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R5
  AST_RSP_AFTER_OE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !$past(mem_oe_n)); // R5
  AST_RELEASE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_ready) |-> ($past(mem_s1) && $past(mem_oe_n) && $past(mem_we_n))); // R6
  AST_BUSY_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R7
  AST_SEL_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    mem_s1 != mem_s2); // R8

endmodule

bind sram_cycle_ctrl sram_cycle_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
  .mem_s1(mem_s1), .mem_s2(mem_s2), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
  .mem_dq_oe(mem_dq_oe)
);

// File: tb/test_sram_cycle_ctrl.sv
`timescale 1ns/1ps
module test_sram_cycle_ctrl;
  localparam int RD_WAIT = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [17:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_valid, mem_s1, mem_s2, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0]  rsp_rdata, mem_dq_out, mem_dq_in;
  logic [17:0] mem_addr;

  int checks = 0, errors = 0, cyc = 0;

  always #10 clk = ~clk;

  sram_cycle_ctrl #(.ADDR_W(18), .DATA_W(8), .RD_WAIT(RD_WAIT)) i_sram_cycle_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_s1(mem_s1), .mem_s2(mem_s2), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // behavioural memory: captures on the first deasserting edge of the write overlap
  logic [7:0]  mem [logic [17:0]];
  logic [7:0]  rd_byte = 8'hEE;
  logic        wr_prev = 1'b0;
  logic [17:0] addr_prev = '0;
  logic [7:0]  data_prev = '0;
  assign mem_dq_in = rd_byte;

  always @(negedge clk) begin
    logic sel_now, wr_now;
    sel_now = !mem_s1 && mem_s2;
    wr_now  = sel_now && !mem_we_n;
    if (wr_prev && !wr_now) mem[addr_prev] = data_prev;
    if (wr_prev && wr_now) chk("R3 addr during strobe", mem_addr, addr_prev);
    if (mem_dq_oe) chk("R4 oe_n while driving", mem_oe_n, 1);
    if (sel_now && mem_we_n && !mem_oe_n)
      rd_byte = mem.exists(mem_addr) ? mem[mem_addr] : 8'h00;
    else
      rd_byte = 8'hEE;
    wr_prev   = wr_now;
    addr_prev = mem_addr;
    data_prev = mem_dq_out;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      errors++; checks++;
      $display("FAIL R7 watchdog: actual busy expected idle");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic do_op(input logic wr, input logic [17:0] a, input logic [7:0] d);
    int busy; logic got; logic [7:0] rd; logic [3:0] exp_pat;
    @(negedge clk);
    chk("R7 ready before request", req_ready, 1);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    busy = 0; got = 1'b0; rd = '0;
    while (!req_ready && busy < 50) begin
      if (wr) begin
        case (busy)
          0: exp_pat = 4'b0110;
          1: exp_pat = 4'b0011;
          2: exp_pat = 4'b0111;
          default: exp_pat = 4'b1111;
        endcase
        chk("R2 write pins", {mem_s1, mem_we_n, mem_oe_n, mem_dq_oe}, exp_pat);
      end else begin
        if (busy == 0) exp_pat = 4'b0110;
        else if (busy <= RD_WAIT) exp_pat = 4'b0100;
        else exp_pat = 4'b1110;
        chk(busy > RD_WAIT ? "R6 read release pins" : "R5 read pins",
            {mem_s1, mem_we_n, mem_oe_n, mem_dq_oe}, exp_pat);
      end
      chk("R8 select pair", mem_s2, !mem_s1);
      if (!mem_s1) chk("R3 address held", mem_addr, a);
      if (rsp_valid) begin
        got = 1'b1; rd = rsp_rdata;
        chk("R9 no response on write", wr, 0);
        chk("R5 response clock", busy, RD_WAIT + 1);
      end
      busy++;
      @(negedge clk);
    end
    chk("R7 busy length", busy, wr ? 4 : RD_WAIT + 2);
    chk("R1 idle pins", {mem_s1, mem_s2, mem_we_n, mem_oe_n, mem_dq_oe, rsp_valid}, 6'b101100);
    if (!wr) begin
      chk("R5 response seen", got, 1);
      chk("R5 read data", rd, d);
    end
  endtask

  // {write, addr[17:0], data or expected read byte}
  localparam logic [26:0] VEC [8] = '{
    {1'b1, 18'h00000, 8'h11},
    {1'b1, 18'h3FFFF, 8'hA5},
    {1'b1, 18'h15555, 8'h3C},
    {1'b1, 18'h2AAAA, 8'hC3},
    {1'b0, 18'h15555, 8'h3C},
    {1'b0, 18'h00000, 8'h11},
    {1'b0, 18'h2AAAA, 8'hC3},
    {1'b0, 18'h3FFFF, 8'hA5}
  };

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset pins", {mem_s1, mem_s2, mem_we_n, mem_oe_n, mem_dq_oe}, 5'b10110);
    chk("R1 reset ready", req_ready, 1);
    chk("R1 reset rsp_valid", rsp_valid, 0);
    rst_n = 1'b1;

    for (int i = 0; i < 8; i++) do_op(VEC[i][26], VEC[i][25:8], VEC[i][7:0]);

    // R7: a conflicting request held during a write must not be taken
    do_op(1'b1, 18'h00100, 8'h5A);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 18'h00200; req_wdata = 8'h77;
    @(negedge clk);
    req_addr = 18'h00100; req_wdata = 8'hFF;
    @(negedge clk);
    chk("R7 strobe keeps first address", mem_addr, 18'h00200);
    chk("R7 strobe keeps first data", mem_dq_out, 8'h77);
    @(negedge clk);
    @(negedge clk);
    chk("R7 still busy in release", req_ready, 0);
    req_valid = 1'b0;
    @(negedge clk);
    chk("R7 idle after ignored request", {req_ready, mem_s1}, 2'b11);
    do_op(1'b0, 18'h00100, 8'h5A);
    do_op(1'b0, 18'h00200, 8'h77);

    // R5/R7: a new request presented in the response clock
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 18'h3FFFF;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid && cyc < 19000) @(negedge clk);
    chk("R5 read data in overlap", rsp_rdata, 8'hA5);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 18'h00300; req_wdata = 8'h99;
    @(negedge clk);
    chk("R6 not taken during release", {req_ready, mem_s1, rsp_valid}, 3'b110);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R7 taken from idle", {req_ready, mem_s1, mem_we_n}, 3'b001);
    chk("R7 new address at setup", mem_addr, 18'h00300);
    while (!req_ready && cyc < 19000) @(negedge clk);
    do_op(1'b0, 18'h00300, 8'h99);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule